// File: doc/BRIEF.md
# Pixel Quad Batch Packer

The block sits between a rasterizer and a pixel-shader scheduler. Each input beat carries one 2x2 pixel quad: a four-bit coverage mask and the screen coordinates of its top-left pixel. The block packs quads, whole and in arrival order, into batches of a fixed number of quads. Every pixel gets one thread lane. A pixel that its sample does not cover still takes its lane, flagged as a helper, so all four pixels of a quad sit in adjacent lanes and screen-space derivatives can be formed across the quad.

A batch is emitted once its last quad slot is filled. It is also emitted early when a beat carries the end flag, which marks either the end of a primitive or a flush. A quad with no covered pixel is dropped, but its end flag still acts. The output presents a live mask, a helper mask and the even-aligned x/y of each packed quad. It holds them until the consumer accepts. The input is stalled while a finished batch waits.

Top module: `quad_warp_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Quad slot k occupies lanes 4k to 4k+3. Coverage bit 0 (top-left), 1 (top-right), 2 (bottom-left) and 3 (bottom-right) map to lanes 4k, 4k+1, 4k+2 and 4k+3. A lane's live bit equals its coverage bit.
- R3: In a packed quad, each uncovered pixel's lane has its helper bit set. `out_live` and `out_helper` never share a set bit.
- R4: A beat whose coverage mask is 0000 is discarded and takes no slot. Later quads fill slots as if it had never arrived.
- R5: A batch is presented on the output as soon as its final slot (the eighth, by default) is filled, with no end flag needed.
- R6: A beat with `in_eop` = 1 presents the partly filled batch that includes that beat's quad. Lanes of unused slots are neither live nor helper, and the coordinate fields of unused slots are zero.
- R7: An end-flagged beat with coverage 0000 emits the pending partial batch if at least one quad is held. If no quad is held, nothing is emitted. An emitted batch always has at least one live lane.
- R8: Slot k's x and y appear at bits [k*CW +: CW] of `out_x` and `out_y`, equal to the input coordinates with bit 0 forced to 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output and its contents hold unchanged. `in_ready` is 0 whenever `out_valid` is 1.
- R10: After a batch is accepted, the next packed quad lands in slot 0 of a cleared batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Quad beat valid |
| in_ready | output | 1 | Quad beat accepted when high with in_valid |
| in_cov | input | 4 | Coverage: bit0 TL, bit1 TR, bit2 BL, bit3 BR |
| in_x | input | CW (12) | Quad x coordinate |
| in_y | input | CW (12) | Quad y coordinate |
| in_eop | input | 1 | End of primitive or flush |
| out_valid | output | 1 | Batch valid |
| out_ready | input | 1 | Batch consumer ready |
| out_live | output | 4*QUADS (32) | Live thread mask |
| out_helper | output | 4*QUADS (32) | Helper thread mask |
| out_x | output | QUADS*CW (96) | Per-slot quad x, even |
| out_y | output | QUADS*CW (96) | Per-slot quad y, even |

## Verification
On every cycle the assertions check the local invariants of a presented batch. Live and helper never overlap. Each quad nibble is either fully occupied or fully empty, and empty slots only trail filled ones. Coordinates are even, a batch is never empty, a stalled batch holds still, and input is blocked while a batch waits. Only the bench's reference model can show the packing itself: which coverage bit lands in which lane, that zero-coverage beats leave no gap, and when a full or end-flagged batch appears. It also shows that a flush with nothing held emits nothing, and that the next batch restarts at slot 0 under varied consumer backpressure.

// File: rtl/quad_warp_packer.sv
module quad_warp_packer #(
  parameter int QUADS = 8,
  parameter int CW = 12,
  localparam int LANES = 4 * QUADS,
  localparam int IW = $clog2(QUADS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [3:0]            in_cov,
  input  logic [CW-1:0]         in_x,
  input  logic [CW-1:0]         in_y,
  input  logic                  in_eop,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES-1:0]      out_live,
  output logic [LANES-1:0]      out_helper,
  output logic [QUADS*CW-1:0]   out_x,
  output logic [QUADS*CW-1:0]   out_y
);

  localparam logic [IW-1:0] FULL_CNT = IW'(QUADS);

  logic [IW-1:0] cnt;
  logic          take, keep, emit;
  logic [IW-1:0] cnt_nxt;

  assign in_ready = !out_valid;
  assign take     = in_valid && in_ready;
  assign keep     = take && (|in_cov);
  assign cnt_nxt  = cnt + IW'(keep);
  assign emit     = take && ((cnt_nxt == FULL_CNT) || (in_eop && cnt_nxt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      out_valid  <= 1'b0;
      out_live   <= '0;
      out_helper <= '0;
      out_x      <= '0;
      out_y      <= '0;
    end else if (out_valid && out_ready) begin
      cnt        <= '0;
      out_valid  <= 1'b0;
      out_live   <= '0;
      out_helper <= '0;
      out_x      <= '0;
      out_y      <= '0;
    end else begin
      if (keep) begin
        out_live[{cnt, 2'b00} +: 4]   <= in_cov;
        out_helper[{cnt, 2'b00} +: 4] <= ~in_cov;
        out_x[cnt*CW +: CW]           <= in_x & ~CW'(1);
        out_y[cnt*CW +: CW]           <= in_y & ~CW'(1);
      end
      cnt <= cnt_nxt;
      if (emit) out_valid <= 1'b1;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live & out_helper) == '0); // R3

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9

  AST_HOLD_BATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_live) && $stable(out_helper)
                                   && $stable(out_x) && $stable(out_y))); // R9

  AST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (|out_live)); // R7

  for (genvar k = 0; k < QUADS; k++) begin : g_slot
    AST_QUAD_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_live[4*k +: 4] | out_helper[4*k +: 4]) inside {4'h0, 4'hF})); // R2
    AST_EVEN_XY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_x[k*CW] && !out_y[k*CW]); // R8
    if (k < QUADS - 1) begin : g_gap
      AST_TRAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_live[4*k +: 4] == 4'h0)) |-> (out_live[4*(k+1) +: 4] == 4'h0)); // R6
    end
  end

endmodule

// File: tb/quad_warp_packer_bench.sv
module quad_warp_packer_bench;
  localparam int Q = 8;
  localparam int CW = 12;
  localparam int L = 4 * Q;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_cov = '0;
  logic [CW-1:0] in_x = '0, in_y = '0;
  logic in_eop = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [L-1:0] out_live, out_helper;
  logic [Q*CW-1:0] out_x, out_y;

  always #4 clk = ~clk;

  quad_warp_packer #(.QUADS(Q), .CW(CW)) u_quad_warp_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cov(in_cov), .in_x(in_x), .in_y(in_y), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_live(out_live),
    .out_helper(out_helper), .out_x(out_x), .out_y(out_y));

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int bp_mode = 0;
  bit done = 0;

  logic [L-1:0] m_live = '0, m_help = '0;
  int m_x[Q];
  int m_y[Q];
  int m_cnt = 0;
  bit m_pend = 0;
  bit mon_on = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_live = '0; m_help = '0; m_cnt = 0; m_pend = 0;
    for (int k = 0; k < Q; k++) begin m_x[k] = 0; m_y[k] = 0; end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      check(out_valid == m_pend, "R5 R6 R7 out_valid", out_valid, m_pend);
      check(in_ready == !m_pend, "R9 in_ready", in_ready, !m_pend);
      if (m_pend) begin
        check(out_live == m_live, "R2 R4 R10 live", out_live, m_live);
        check(out_helper == m_help, "R3 R6 helper", out_helper, m_help);
        for (int k = 0; k < Q; k++) begin
          check(int'(out_x[k*CW +: CW]) == m_x[k], "R8 R6 x", out_x[k*CW +: CW], m_x[k]);
          check(int'(out_y[k*CW +: CW]) == m_y[k], "R8 R6 y", out_y[k*CW +: CW], m_y[k]);
        end
      end
      if (m_pend && out_ready) model_clear();
      else if (!m_pend && in_valid) begin
        if (in_cov != 4'h0) begin
          m_live[4*m_cnt +: 4] = in_cov;
          m_help[4*m_cnt +: 4] = ~in_cov;
          m_x[m_cnt] = int'(in_x) - (int'(in_x) % 2);
          m_y[m_cnt] = int'(in_y) - (int'(in_y) % 2);
          m_cnt++;
        end
        if (m_cnt == Q || (in_eop && m_cnt != 0)) m_pend = 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cycles % 5 == 0);
      default: out_ready = ($urandom_range(0, 2) == 0);
    endcase
  end

  task automatic send(input logic [3:0] c, input int x, input int y, input bit e);
    bit acc;
    in_valid = 1'b1; in_cov = c; in_x = CW'(x); in_y = CW'(y); in_eop = e;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && m_pend; i++) @(posedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    mon_on = 1;
    @(posedge clk); #1;

    // R5 full batch, varied coverage
    for (int i = 0; i < Q; i++) send(4'(i + 1), 2 * i, 10 + 2 * i, 0);
    drain();

    // R4 zero-coverage beats interleaved, R10 restarts at slot 0
    for (int i = 0; i < 20; i++) send((i % 3 == 0) ? 4'h0 : 4'(i * 7), 3 * i, 5 * i + 1, 0);
    send(4'h9, 101, 203, 1);
    drain();

    // R6 partial batch by end flag, odd coordinates
    send(4'h1, 7, 9, 0);
    send(4'h8, 15, 33, 0);
    send(4'hF, 4095, 4095, 1);
    drain();

    // R7 flush with nothing held emits nothing
    send(4'h0, 0, 0, 1);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7 empty flush", out_valid, 0);
    @(posedge clk); #1;

    // R7 flush with held quads
    send(4'h6, 20, 40, 0);
    send(4'h0, 0, 0, 1);
    drain();

    // R9 backpressure patterns
    bp_mode = 1;
    for (int i = 0; i < 30; i++) send(4'((i * 5) % 16), i, 2 * i, (i % 11 == 10));
    send(4'hC, 1, 1, 1);
    drain();
    bp_mode = 2;
    for (int i = 0; i < 40; i++) send(4'($urandom_range(0, 15)), $urandom_range(0, 4095),
                                      $urandom_range(0, 4095), ($urandom_range(0, 6) == 0));
    send(4'h3, 2, 2, 1);
    drain();
    bp_mode = 0;
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    wait (done || cycles > 50000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule